// File: doc/BRIEF.md
# Page-Mode Pseudo-SRAM Access Controller

This block connects a synchronous request stream to an asynchronous pseudo-SRAM that uses SRAM-style strobes. The strobes are an active-low chip select, an active-low output enable, an active-low write strobe and two active-low byte-lane selects. The 16-bit data path is split into separate output, output-enable and input signals, and a pad cell at chip level combines them. The controller uses no analog delays. Every device timing limit is expressed in picoseconds, and the controller converts it to a whole number of system clocks, rounding up. It holds each strobe phase for that number of clocks.

Every request carries the following:
- a word address;
- a write flag;
- a write word;
- two active-high byte enables;
- a burst length.

A write stores the enabled lanes of one word. A read returns words from one 8-word page. The first word is held for the full random-access time. The following words change only the three low address bits, and each of them needs only the shorter page time. A burst ends at the requested length, at the page boundary, or when one more word would make the chip-select-low window exceed the device's maximum active time. The controller returns each read word as a one-clock pulse on the response port.

Back-pressure on the request side works as follows. `req_ready` is high only while the controller is idle. A request transfers on a clock edge where both `req_valid` and `req_ready` are high. The request fields must stay stable while `req_valid` is high and the transfer has not yet happened. The response port cannot be stalled, so the consumer must take every `rsp_valid` pulse.

Top module: `psram_page_ctrl`

## Requirements
- R1: While reset is high, and in the first idle cycle after it, all five strobes are high, `psram_dq_oe` is 0, `req_ready` is 1 and `rsp_valid` is 0.
- R2: A read holds its first word with chip select and output enable low and a stable address for RC cycles. RC is the larger of the rounded-up random cycle time and output-enable access time, which is 9 at 8 ns. The sampled word appears with a one-cycle `rsp_valid` pulse in the cycle after the word ends.
- R3: In a burst, the address bits above bit 2 stay fixed and bits 2:0 increase by one per word. Each word after the first lasts PC cycles, which is 3 at 8 ns. The number of words is the smallest of three limits: the effective length, 8 minus the starting bits 2:0, and the active-time limit of R9.
- R4: A burst length of 0 is treated as 1, and any length above 8 is treated as 8.
- R5: `req_ready` is high only in the idle state, so it is never high while chip select is low. Between two accesses, chip select stays high for at least 3 cycles: 2 cycles of rounded-up select-high recovery, then one idle cycle.
- R6: Byte enable bit 0 selects bits 7:0 through `psram_lb_n`, and bit 1 selects bits 15:8 through `psram_ub_n`; both pins are active low. A read returns zero in every lane that is not enabled. A write changes only the enabled lanes, so a write with both enables at 0 changes nothing.
- R7: A write has two phases:
  - The write strobe is low for the larger of the rounded-up write-pulse and address-valid-to-end times, which is 8 cycles.
  - Chip select then stays low for 1 more cycle, so the access lasts 9 cycles.
  - The data bus is driven throughout the write, and output enable stays high whenever the controller drives the bus.
- R8: When a write follows a read, the controller adds one turnaround cycle. The chip-select-high gap between the two accesses is then 4 cycles when the write is presented at once.
- R9: Chip select never stays low for more than the rounded-up maximum active time. A read burst is cut short before any word that would break this limit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 21 | Word address |
| req_wdata | input | 16 | Write word |
| req_ben | input | 2 | Byte enables, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| req_len | input | 4 | Read burst length in words |
| rsp_valid | output | 1 | One-cycle pulse per returned read word |
| rsp_data | output | 16 | Returned word, lanes that are not enabled are zero |
| psram_addr | output | 21 | Device address |
| psram_ce_n | output | 1 | Chip select, active low |
| psram_oe_n | output | 1 | Output enable, active low |
| psram_we_n | output | 1 | Write strobe, active low |
| psram_lb_n | output | 1 | Lower byte select, active low |
| psram_ub_n | output | 1 | Upper byte select, active low |
| psram_dq_o | output | 16 | Data toward the device |
| psram_dq_oe | output | 1 | Drive enable for `psram_dq_o` |
| psram_dq_i | input | 16 | Data from the device |

## Verification
The assertions assume three things about the environment:
- it holds request fields stable while `req_valid` waits;
- it never needs to stall a response;
- the device drives `psram_dq_i` only while output enable is low.

The active-time checks also assume that the random cycle time fits inside the maximum active window, because otherwise no read could ever be legal. The bench changes request fields only on the falling clock edge and waits for `req_ready` before a transfer. It consumes every response in the cycle it appears. Its device model drives filler bytes onto lanes that are not selected or not being read, so any masking error shows up in the returned data.

// File: rtl/psram_ctrl_pkg.sv
package psram_ctrl_pkg;

  function automatic int unsigned ps_to_cyc(input int unsigned t_ps, input int unsigned clk_ps);
    return (t_ps + clk_ps - 1) / clk_ps;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TURN,
    ST_RD,
    ST_WR_LO,
    ST_WR_HI,
    ST_REC
  } ctrl_state_e;

endpackage

// File: rtl/psram_cycle_timer.sv
module psram_cycle_timer #(
  parameter int unsigned TMR_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [TMR_W-1:0] load_val,
  output logic             last
);
  logic [TMR_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - TMR_W'(1);
    end
  end

  assign last = (cnt_q == TMR_W'(1));

  // R2 / R7: a phase is never started with a zero length
  a_r2_nonzero_load: assert property (@(posedge clk) disable iff (rst)
    load |-> (load_val != '0));
endmodule

// File: rtl/psram_active_guard.sv
module psram_active_guard #(
  parameter int unsigned MAX_CYC  = 1250,
  parameter int unsigned STEP_CYC = 3,
  localparam int unsigned CNT_W   = $clog2(MAX_CYC + 2)
) (
  input  logic clk,
  input  logic rst,
  input  logic active,
  output logic can_extend
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      cnt_q <= '0;
    end else if (cnt_q != '1) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  // cycles elapsed at the end of the current cycle plus one more page word
  assign can_extend = ({1'b0, cnt_q} + (CNT_W+1)'(STEP_CYC + 1)) <= (CNT_W+1)'(MAX_CYC);

  a_r9_active_bound: assert property (@(posedge clk) disable iff (rst)
    active |-> ({1'b0, cnt_q} < (CNT_W+1)'(MAX_CYC)));
endmodule

// File: rtl/psram_byte_lanes.sv
module psram_byte_lanes #(
  parameter int unsigned LANES = 2
) (
  input  logic               active,
  input  logic [LANES-1:0]   ben,
  input  logic [8*LANES-1:0] rd_raw,
  output logic [LANES-1:0]   sel_n,
  output logic [8*LANES-1:0] rd_masked
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign sel_n[g] = !(active && ben[g]);
    assign rd_masked[8*g +: 8] = ben[g] ? rd_raw[8*g +: 8] : 8'h00;
  end
endmodule

// File: rtl/psram_page_ctrl.sv
module psram_page_ctrl
  import psram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W       = 21,
  parameter int unsigned DATA_W       = 16,
  parameter int unsigned PAGE_BITS    = 3,
  parameter int unsigned LEN_W        = 4,
  parameter int unsigned CLK_PS       = 8000,
  parameter int unsigned T_RC_PS      = 65000,
  parameter int unsigned T_PC_PS      = 20000,
  parameter int unsigned T_OE_PS      = 25000,
  parameter int unsigned T_WC_PS      = 65000,
  parameter int unsigned T_WP_PS      = 50000,
  parameter int unsigned T_AW_PS      = 60000,
  parameter int unsigned T_CEH_PS     = 10000,
  parameter int unsigned T_ACT_MAX_PS = 10000000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [1:0]        req_ben,
  input  logic [LEN_W-1:0]  req_len,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic [ADDR_W-1:0] psram_addr,
  output logic              psram_ce_n,
  output logic              psram_oe_n,
  output logic              psram_we_n,
  output logic              psram_lb_n,
  output logic              psram_ub_n,
  output logic [DATA_W-1:0] psram_dq_o,
  output logic              psram_dq_oe,
  input  logic [DATA_W-1:0] psram_dq_i
);
  localparam int unsigned LANES      = DATA_W / 8;
  localparam int unsigned PAGE_WORDS = 1 << PAGE_BITS;
  localparam int unsigned RC_CYC     = max2(ps_to_cyc(T_RC_PS, CLK_PS), ps_to_cyc(T_OE_PS, CLK_PS));
  localparam int unsigned PC_CYC     = max2(ps_to_cyc(T_PC_PS, CLK_PS), 1);
  localparam int unsigned WLOW_CYC   = max2(ps_to_cyc(T_WP_PS, CLK_PS), ps_to_cyc(T_AW_PS, CLK_PS));
  localparam int unsigned WC_CYC     = ps_to_cyc(T_WC_PS, CLK_PS);
  localparam int unsigned WTAIL_CYC  = (WC_CYC > WLOW_CYC) ? (WC_CYC - WLOW_CYC) : 1;
  localparam int unsigned CEH_CYC    = max2(ps_to_cyc(T_CEH_PS, CLK_PS), 1);
  localparam int unsigned MAX_CYC    = ps_to_cyc(T_ACT_MAX_PS, CLK_PS);
  localparam int unsigned TMR_W      = $clog2(RC_CYC + PC_CYC + WLOW_CYC + WTAIL_CYC + CEH_CYC + 1);
  localparam int unsigned UP_W       = ADDR_W - PAGE_BITS;

  ctrl_state_e state_q, state_d;

  logic [UP_W-1:0]      up_q;
  logic [PAGE_BITS-1:0] lo_q;
  logic [LANES-1:0]     ben_q;
  logic [DATA_W-1:0]    wdata_q;
  logic [LEN_W-1:0]     left_q;
  logic [LEN_W-1:0]     len_eff;
  logic                 last_rd_q;

  logic                 tmr_load;
  logic [TMR_W-1:0]     tmr_val;
  logic                 tmr_last;
  logic                 active;
  logic                 can_extend;
  logic                 more_words;
  logic [LANES-1:0]     sel_n;
  logic [DATA_W-1:0]    rd_masked;

  assign active = (state_q == ST_RD) || (state_q == ST_WR_LO) || (state_q == ST_WR_HI);

  always_comb begin
    if (req_len == '0)                              len_eff = LEN_W'(1);
    else if (req_len > LEN_W'(PAGE_WORDS))          len_eff = LEN_W'(PAGE_WORDS);
    else                                            len_eff = req_len;
  end

  assign more_words = (left_q > LEN_W'(1)) && (lo_q != '1) && can_extend;

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = TMR_W'(1);
    unique case (state_q)
      ST_IDLE: if (req_valid) begin
        if (!req_write) begin
          state_d = ST_RD;  tmr_load = 1'b1; tmr_val = TMR_W'(RC_CYC);
        end else if (last_rd_q) begin
          state_d = ST_TURN;
        end else begin
          state_d = ST_WR_LO; tmr_load = 1'b1; tmr_val = TMR_W'(WLOW_CYC);
        end
      end
      ST_TURN: begin
        state_d = ST_WR_LO; tmr_load = 1'b1; tmr_val = TMR_W'(WLOW_CYC);
      end
      ST_RD: if (tmr_last) begin
        tmr_load = 1'b1;
        if (more_words) begin
          state_d = ST_RD;  tmr_val = TMR_W'(PC_CYC);
        end else begin
          state_d = ST_REC; tmr_val = TMR_W'(CEH_CYC);
        end
      end
      ST_WR_LO: if (tmr_last) begin
        state_d = ST_WR_HI; tmr_load = 1'b1; tmr_val = TMR_W'(WTAIL_CYC);
      end
      ST_WR_HI: if (tmr_last) begin
        state_d = ST_REC; tmr_load = 1'b1; tmr_val = TMR_W'(CEH_CYC);
      end
      ST_REC: if (tmr_last) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      up_q      <= '0;
      lo_q      <= '0;
      ben_q     <= '0;
      wdata_q   <= '0;
      left_q    <= '0;
      last_rd_q <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      state_q   <= state_d;
      rsp_valid <= 1'b0;
      case (state_q)
        ST_IDLE: if (req_valid) begin
          up_q    <= req_addr[ADDR_W-1:PAGE_BITS];
          lo_q    <= req_addr[PAGE_BITS-1:0];
          ben_q   <= req_ben;
          wdata_q <= req_wdata;
          left_q  <= len_eff;
        end
        ST_RD: if (tmr_last) begin
          rsp_valid <= 1'b1;
          rsp_data  <= rd_masked;
          if (more_words) begin
            lo_q   <= lo_q + PAGE_BITS'(1);
            left_q <= left_q - LEN_W'(1);
          end else begin
            last_rd_q <= 1'b1;
          end
        end
        ST_WR_LO: last_rd_q <= 1'b0;
        default: ;
      endcase
    end
  end

  psram_cycle_timer #(.TMR_W(TMR_W)) i_timer (
    .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .last(tmr_last)
  );

  psram_active_guard #(.MAX_CYC(MAX_CYC), .STEP_CYC(PC_CYC)) i_guard (
    .clk(clk), .rst(rst), .active(active), .can_extend(can_extend)
  );

  psram_byte_lanes #(.LANES(LANES)) i_lanes (
    .active(active), .ben(ben_q), .rd_raw(psram_dq_i), .sel_n(sel_n), .rd_masked(rd_masked)
  );

  assign req_ready   = (state_q == ST_IDLE);
  assign psram_addr  = {up_q, lo_q};
  assign psram_ce_n  = !active;
  assign psram_oe_n  = (state_q != ST_RD);
  assign psram_we_n  = (state_q != ST_WR_LO);
  assign psram_dq_oe = (state_q == ST_WR_LO) || (state_q == ST_WR_HI);
  assign psram_dq_o  = wdata_q;
  assign psram_lb_n  = sel_n[0];
  assign psram_ub_n  = sel_n[LANES-1];

  a_r5_ready_only_idle: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> psram_ce_n);

  a_r3_page_upper_fixed: assert property (@(posedge clk) disable iff (rst)
    (!psram_ce_n && $past(!psram_ce_n)) |->
      (psram_addr[ADDR_W-1:PAGE_BITS] == $past(psram_addr[ADDR_W-1:PAGE_BITS])));

  a_r7_no_contention: assert property (@(posedge clk) disable iff (rst)
    psram_dq_oe |-> psram_oe_n);

  a_r7_we_inside_ce: assert property (@(posedge clk) disable iff (rst)
    !psram_we_n |-> !psram_ce_n);

  a_r2_rsp_after_oe: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(!psram_oe_n));
endmodule

// File: tb/test_psram_page_ctrl.sv
module test_psram_page_ctrl;
  localparam int CLK_PS  = 8000;
  localparam int MAX_PS  = 200000;
  localparam int RC      = 9;
  localparam int PC      = 3;
  localparam int WLOW    = 8;
  localparam int WTOT    = 9;
  localparam int MAXC    = (MAX_PS + CLK_PS - 1) / CLK_PS;
  localparam int MAXW    = 1 + (MAXC - RC) / PC;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4ns clk = ~clk;

  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [20:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_ben = '0;
  logic [3:0]  req_len = '0;
  logic        req_ready, rsp_valid;
  logic [15:0] rsp_data;
  logic [20:0] psram_addr;
  logic        psram_ce_n, psram_oe_n, psram_we_n, psram_lb_n, psram_ub_n, psram_dq_oe;
  logic [15:0] psram_dq_o, psram_dq_i;

  psram_page_ctrl #(.T_ACT_MAX_PS(MAX_PS)) i_psram_page_ctrl (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ben(req_ben), .req_len(req_len),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .psram_addr(psram_addr), .psram_ce_n(psram_ce_n), .psram_oe_n(psram_oe_n),
    .psram_we_n(psram_we_n), .psram_lb_n(psram_lb_n), .psram_ub_n(psram_ub_n),
    .psram_dq_o(psram_dq_o), .psram_dq_oe(psram_dq_oe), .psram_dq_i(psram_dq_i)
  );

  int checks = 0;
  int errors = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // device model and bench shadow
  logic [15:0] dev_mem [int];
  logic [15:0] shadow  [int];

  function automatic logic [15:0] init_word(input logic [20:0] a);
    return a[15:0] ^ 16'h5A3C;
  endfunction

  function automatic logic [15:0] dev_rd(input logic [20:0] a);
    return dev_mem.exists(int'(a)) ? dev_mem[int'(a)] : init_word(a);
  endfunction

  function automatic logic [15:0] sh_rd(input logic [20:0] a);
    return shadow.exists(int'(a)) ? shadow[int'(a)] : init_word(a);
  endfunction

  logic [15:0] raw;
  assign raw = dev_rd(psram_addr);
  assign psram_dq_i[7:0]  = (!psram_ce_n && !psram_oe_n && !psram_lb_n) ? raw[7:0]  : 8'hEE;
  assign psram_dq_i[15:8] = (!psram_ce_n && !psram_oe_n && !psram_ub_n) ? raw[15:8] : 8'hEE;

  logic we_lo_prev = 1'b0;
  always @(negedge clk) begin
    if (!psram_ce_n && we_lo_prev && psram_we_n) begin
      logic [15:0] w;
      w = dev_rd(psram_addr);
      if (!psram_lb_n) w[7:0]  = psram_dq_o[7:0];
      if (!psram_ub_n) w[15:8] = psram_dq_o[15:8];
      dev_mem[int'(psram_addr)] = w;
    end
    we_lo_prev = !psram_we_n;
  end

  // scoreboard
  logic [15:0] exp_q [$];

  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R3", "unexpected response word", rsp_data, 0);
      end else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        check(rsp_data == e, "R2", "read data", rsp_data, e);
      end
    end
  end

  // timing monitor
  int          rd_run = 0, we_run = 0, ce_run = 0, gap = 0, last_gap = 0;
  bit          rd_first = 1'b0, saw_we = 1'b0, had_access = 1'b0;
  logic [20:0] rd_addr = '0;

  always @(negedge clk) begin
    if (!rst) begin
      check(!(psram_dq_oe && !psram_oe_n), "R7", "bus contention", psram_oe_n, 1);
      if (!psram_ce_n) check(!req_ready, "R5", "ready while active", req_ready, 0);
      // read word runs
      if (!psram_ce_n && !psram_oe_n) begin
        if (rd_run == 0) begin
          rd_first = 1'b1; rd_run = 1; rd_addr = psram_addr;
        end else if (psram_addr != rd_addr) begin
          check(rd_run == (rd_first ? RC : PC), rd_first ? "R2" : "R3", "word length", rd_run, rd_first ? RC : PC);
          check(psram_addr == rd_addr + 21'd1 && psram_addr[20:3] == rd_addr[20:3], "R3",
                "page step address", psram_addr, rd_addr + 21'd1);
          rd_first = 1'b0; rd_run = 1; rd_addr = psram_addr;
        end else begin
          rd_run++;
        end
      end else if (rd_run > 0) begin
        check(rd_run == (rd_first ? RC : PC), rd_first ? "R2" : "R3", "last word length", rd_run, rd_first ? RC : PC);
        rd_run = 0;
      end
      // write strobe
      if (!psram_we_n) begin
        we_run++; saw_we = 1'b1;
      end else if (we_run > 0) begin
        check(we_run == WLOW, "R7", "write strobe length", we_run, WLOW);
        we_run = 0;
      end
      // chip select windows and gaps
      if (!psram_ce_n) begin
        if (ce_run == 0) begin
          last_gap = gap;
          if (had_access) check(gap >= 3, "R5", "select-high gap", gap, 3);
          had_access = 1'b1;
        end
        ce_run++; gap = 0;
      end else begin
        if (ce_run > 0) begin
          if (saw_we) check(ce_run == WTOT, "R7", "write access length", ce_run, WTOT);
          else        check(ce_run <= MAXC, "R9", "active window", ce_run, MAXC);
          ce_run = 0; saw_we = 1'b0;
        end
        gap++;
      end
    end
  end

  task automatic do_req(input bit wr, input logic [20:0] a, input logic [15:0] d,
                        input logic [1:0] be, input logic [3:0] len);
    if (wr) begin
      logic [15:0] w;
      w = sh_rd(a);
      if (be[0]) w[7:0]  = d[7:0];
      if (be[1]) w[15:8] = d[15:8];
      shadow[int'(a)] = w;
    end else begin
      int l, n;
      l = (len == 0) ? 1 : (len > 8) ? 8 : int'(len);
      n = l;
      if (8 - int'(a[2:0]) < n) n = 8 - int'(a[2:0]);
      if (MAXW < n) n = MAXW;
      for (int i = 0; i < n; i++) begin
        logic [15:0] v;
        v = sh_rd(a + 21'(i));
        exp_q.push_back({be[1] ? v[15:8] : 8'h00, be[0] ? v[7:0] : 8'h00});
      end
    end
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_ben = be; req_len = len;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    req_valid <= 1'b0;
  endtask

  task automatic settle();
    repeat (30) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check(psram_ce_n && psram_oe_n && psram_we_n && psram_lb_n && psram_ub_n, "R1",
          "strobes in reset", {psram_ce_n, psram_oe_n, psram_we_n, psram_lb_n, psram_ub_n}, 5'h1f);
    rst = 1'b0;
    @(negedge clk);
    check(req_ready && !rsp_valid && !psram_dq_oe && psram_ce_n, "R1", "idle after reset",
          {req_ready, rsp_valid, psram_dq_oe, psram_ce_n}, 4'b1001);

    // R7 / R2: word write then single read
    do_req(1'b1, 21'h00010, 16'h1234, 2'b11, 4'd1);
    settle();
    do_req(1'b0, 21'h00010, 16'h0, 2'b11, 4'd1);
    settle();
    // R6: byte lane writes and masked reads
    do_req(1'b1, 21'h00011, 16'hBEEF, 2'b01, 4'd1);
    settle();
    do_req(1'b1, 21'h00012, 16'hC0DE, 2'b10, 4'd1);
    settle();
    do_req(1'b1, 21'h00013, 16'hFFFF, 2'b00, 4'd1);
    settle();
    do_req(1'b0, 21'h00011, 16'h0, 2'b11, 4'd3);
    settle();
    do_req(1'b0, 21'h00010, 16'h0, 2'b10, 4'd2);
    settle();
    do_req(1'b0, 21'h00012, 16'h0, 2'b01, 4'd2);
    settle();
    // R3: bursts
    do_req(1'b0, 21'h1A5100, 16'h0, 2'b11, 4'd4);
    settle();
    do_req(1'b0, 21'h002105, 16'h0, 2'b11, 4'd8);
    settle();
    // R9: aligned full burst truncated by active window
    do_req(1'b0, 21'h003100, 16'h0, 2'b11, 4'd8);
    settle();
    // R4: length encodings
    do_req(1'b0, 21'h004200, 16'h0, 2'b11, 4'd0);
    settle();
    do_req(1'b0, 21'h004204, 16'h0, 2'b11, 4'd12);
    settle();
    // R8: read then write back to back
    do_req(1'b0, 21'h00020, 16'h0, 2'b11, 4'd1);
    do_req(1'b1, 21'h00021, 16'h7788, 2'b11, 4'd1);
    settle();
    check(last_gap == 4, "R8", "read-to-write gap", last_gap, 4);
    // R5: read then read back to back
    do_req(1'b0, 21'h00021, 16'h0, 2'b11, 4'd1);
    do_req(1'b0, 21'h00022, 16'h0, 2'b11, 4'd1);
    settle();
    check(last_gap == 3, "R5", "read-to-read gap", last_gap, 3);
    // R5: write then write back to back
    do_req(1'b1, 21'h00030, 16'h1111, 2'b11, 4'd1);
    do_req(1'b1, 21'h00031, 16'h2222, 2'b11, 4'd1);
    settle();
    check(last_gap == 3, "R5", "write-to-write gap", last_gap, 3);
    do_req(1'b0, 21'h00030, 16'h0, 2'b11, 4'd2);
    settle();

    check(exp_q.size() == 0, "R3", "words still expected", exp_q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog R5 actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule